// File: doc/BRIEF.md
# Serial Bitmap Row Loader

This block receives frames over a three-wire serial link framed by an active-low chip select and turns them into writes to a 16-row by 100-column pixel latch array, or into updates of a 4-bit contrast code. The chip-select, serial-clock and data lines come from a slower host. All three pass through two-flop synchronizers into the system clock domain, and their edges are detected there. Data is captured on each rising edge of the serial clock while chip select is low. A 105-bit shift window keeps only the most recent bits.

When chip select rises, the newest bit is the mode flag and decides what the frame does. With the flag at 0, the four bits before it give the row number. The 100 bits before those become that row's pixels, with the first pixel sent landing in column 0. With the flag at 1, the four bits before it are loaded as the contrast code, and the block needs only those five bits. A row frame that is too short to be complete raises an error flag and does not touch the array. A display scanner reads any row through a combinational read port.

Top module: `bitmap_row_loader`

## Requirements
- R1: Bits are taken from `sdi_i` only on rising edges of `sck_i` while `cs_ni` is low. Serial clock edges while `cs_ni` is high leave the frame unchanged, so a later select pulse with no clocks writes nothing.
- R2: In a row frame, the first pixel bit sent goes to `rd_data_o[0]` and the 100th goes to `rd_data_o[99]`. The four row bits come next, most significant first, and the flag is the last bit.
- R3: When `cs_ni` rises after at least 105 bits with the last bit 0, the 100 pixel bits are written into the row named by the row bits (binary 0 to 15). Every other row keeps its contents.
- R4: When more than 105 bits arrive in one frame, only the last 105 bits are decoded and the earlier ones are discarded.
- R5: When `cs_ni` rises after at least 5 bits with the last bit 1, `contrast_o` takes the four bits before the flag, sent in the order bit 3, bit 2, bit 1, bit 0. Earlier bits are ignored and the latch array is not changed.
- R6: A frame of 1 to 4 bits whose last bit is 1, or a frame with no bits, changes neither the array, `contrast_o` nor `short_err_o`.
- R7: A frame of 1 to 104 bits whose last bit is 0 sets `short_err_o` and writes no row. `short_err_o` clears when the next frame starts, which is when `cs_ni` falls.
- R8: While `rst_ni` is low, every latch row reads all zeros, `contrast_o` is 4'b1111 and `short_err_o` is 0.
- R9: `rd_data_o` shows the row selected by `rd_row_i` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Frame select, active low, asynchronous to clk_i |
| sck_i | input | 1 | Serial clock, data captured on its rising edge |
| sdi_i | input | 1 | Serial data |
| rd_row_i | input | 4 | Row selected for the read port |
| rd_data_o | output | 100 | Pixels of the selected row, column 0 in bit 0 |
| contrast_o | output | 4 | Contrast code, 4'b1111 after reset |
| short_err_o | output | 1 | Last row frame was shorter than 105 bits |

## Verification
The bench sends overlong frames with leading junk. A design that decoded the first 105 bits instead of the last would write the wrong row and the wrong pixels. It sends 5-bit contrast commands and contrast commands carried on full-length frames. A design that demanded a full frame or decoded the wrong bit positions would leave the contrast code stale or scrambled. It sends truncated row frames, 4-bit flagged frames, empty select pulses and clocks with select high. A design that committed partial frames or shifted while deselected would corrupt rows, which the row sweep after each frame exposes, and the reset checks catch a contrast code that does not come up at all ones.

// File: rtl/brl_pkg.sv
package brl_pkg;
  localparam int ROWS       = 16;
  localparam int COLS       = 100;
  localparam int ROW_W      = $clog2(ROWS);
  localparam int CODE_W     = 4;
  localparam int FRAME_BITS = COLS + ROW_W + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/brl_sync.sv
module brl_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/brl_frame_rx.sv
module brl_frame_rx #(
  parameter int FRAME_BITS = 105,
  parameter int CNT_W      = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  output logic                  start_o,
  output logic                  commit_o,
  output logic [FRAME_BITS-1:0] win_o,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

  logic cs_s, sck_s, sdi_s;
  logic cs_q, sck_q;
  logic sck_rise, shift_en;

  brl_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   ({cs_s, sck_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign start_o  = ~cs_s & cs_q;
  assign commit_o = cs_s & ~cs_q;
  assign shift_en = sck_rise & ~cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o <= '0;
      cnt_o <= '0;
    end else begin
      if (shift_en) win_o <= {win_o[FRAME_BITS-2:0], sdi_s};
      if (start_o)
        cnt_o <= shift_en ? CNT_W'(1) : '0;
      else if (shift_en && cnt_o != CNT_MAX)
        cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_MAX);

  p_hold_deselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && !start_o) |=> $stable(win_o));
endmodule

// File: rtl/brl_row_store.sv
module brl_row_store #(
  parameter int ROWS  = 16,
  parameter int COLS  = 100,
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [COLS-1:0]  wr_data_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic [COLS-1:0]  rd_data_o
);
  logic [COLS-1:0] mem [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[r] <= '0;
      else if (wr_en_i && wr_row_i == ROW_W'(r)) mem[r] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_row_i];

  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem[$past(wr_row_i)] == $past(wr_data_i));
endmodule

// File: rtl/bitmap_row_loader.sv
module bitmap_row_loader #(
  parameter int ROWS   = brl_pkg::ROWS,
  parameter int COLS   = brl_pkg::COLS,
  parameter int CODE_W = brl_pkg::CODE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     sck_i,
  input  logic                     sdi_i,
  input  logic [$clog2(ROWS)-1:0]  rd_row_i,
  output logic [COLS-1:0]          rd_data_o,
  output logic [CODE_W-1:0]        contrast_o,
  output logic                     short_err_o
);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int FRAME_BITS = COLS + ROW_W + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int CMD_BITS   = CODE_W + 1;

  logic                  start, commit;
  logic [FRAME_BITS-1:0] win;
  logic [CNT_W-1:0]      cnt;
  logic                  flag, full_frame, cmd_ok, nonempty;
  logic                  row_wr, ctr_ld, err_set;
  logic [COLS-1:0]       row_data;

  brl_frame_rx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .sdi_i   (sdi_i),
    .start_o (start),
    .commit_o(commit),
    .win_o   (win),
    .cnt_o   (cnt)
  );

  // first pixel sent sits at the oldest end of the window
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign row_data[c] = win[FRAME_BITS-1-c];
  end

  assign flag       = win[0];
  assign nonempty   = cnt != '0;
  assign full_frame = cnt == CNT_W'(FRAME_BITS);
  assign cmd_ok     = cnt >= CNT_W'(CMD_BITS);
  assign row_wr     = commit & ~flag & full_frame;
  assign ctr_ld     = commit & flag & cmd_ok;
  assign err_set    = commit & ~flag & nonempty & ~full_frame;

  brl_row_store #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (row_wr),
    .wr_row_i (win[ROW_W:1]),
    .wr_data_i(row_data),
    .rd_row_i (rd_row_i),
    .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      contrast_o  <= '1;
      short_err_o <= 1'b0;
    end else begin
      if (ctr_ld) contrast_o <= win[CODE_W:1];
      if (start) short_err_o <= 1'b0;
      else if (err_set) short_err_o <= 1'b1;
    end
  end

  p_one_action_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(row_wr && ctr_ld));

  p_err_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(short_err_o) |-> !$past(row_wr));

  p_ctr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(contrast_o));
endmodule

// File: tb/test_bitmap_row_loader.sv
module test_bitmap_row_loader;
  localparam int FB = 105;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, sck_i = 1'b1, sdi_i = 1'b0;
  logic [3:0]  rd_row_i = '0;
  logic [99:0] rd_data_o;
  logic [3:0]  contrast_o;
  logic        short_err_o;

  int errors = 0, checks = 0;
  bit chk_en = 1'b0;
  bit fq[$];
  logic [99:0] m_mem [16];
  logic [3:0]  m_ctr;
  logic        m_err;

  always #4 clk = ~clk;

  bitmap_row_loader i_bitmap_row_loader (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .sdi_i(sdi_i),
    .rd_row_i(rd_row_i), .rd_data_o(rd_data_o), .contrast_o(contrast_o),
    .short_err_o(short_err_o)
  );

  task automatic check(input string req, input logic [99:0] act, input logic [99:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compared on every clock while no frame is in flight
  always @(negedge clk) if (chk_en) begin
    check("R5 contrast", 100'(contrast_o), 100'(m_ctr));
    check("R7 short_err", 100'(short_err_o), 100'(m_err));
  end

  task automatic sweep(input string req);
    for (int r = 0; r < 16; r++) begin
      rd_row_i = 4'(r);
      #1;
      check(req, rd_data_o, m_mem[r]);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 16; r++) m_mem[r] = '0;
    m_ctr = 4'hF;
    m_err = 1'b0;
  endtask

  task automatic model_commit();
    int n = fq.size();
    if (n == 0) return;
    if (fq[n-1]) begin
      if (n >= 5) m_ctr = {fq[n-5], fq[n-4], fq[n-3], fq[n-2]};
    end else if (n >= FB) begin
      logic [99:0] d;
      for (int i = 0; i < 100; i++) d[i] = fq[n-FB+i];
      m_mem[{fq[n-5], fq[n-4], fq[n-3], fq[n-2]}] = d;
    end else m_err = 1'b1;
  endtask

  task automatic send_frame();
    chk_en = 1'b0;
    sck_i = 1'b1;
    repeat (6) @(posedge clk);
    cs_ni = 1'b0;
    m_err = 1'b0;
    repeat (6) @(posedge clk);
    foreach (fq[i]) begin
      sck_i = 1'b0; sdi_i = fq[i];
      repeat (5) @(posedge clk);
      sck_i = 1'b1;
      repeat (5) @(posedge clk);
    end
    cs_ni = 1'b1;
    model_commit();
    repeat (8) @(posedge clk);
    chk_en = 1'b1;
  endtask

  task automatic mk_row(input logic [99:0] d, input logic [3:0] row);
    for (int i = 0; i < 100; i++) fq.push_back(d[i]);
    for (int i = 3; i >= 0; i--) fq.push_back(row[i]);
    fq.push_back(1'b0);
  endtask

  task automatic mk_ctr(input logic [3:0] c);
    for (int i = 3; i >= 0; i--) fq.push_back(c[i]);
    fq.push_back(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    sweep("R8 reset rows");
    check("R8 reset contrast", 100'(contrast_o), 100'(4'hF));
    check("R8 reset err", 100'(short_err_o), 100'(0));
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    chk_en = 1'b1;

    // R2 R3 single-bit pixel marks column 0 on row 0
    fq.delete(); mk_row(100'h1, 4'h0); send_frame(); sweep("R2 R3 row0");
    fq.delete(); mk_row({1'b1, 99'h0}, 4'hF); send_frame(); sweep("R2 R3 row15");
    fq.delete(); mk_row(100'hA5A5_5A5A_F00F_1234_5678_9ABC_D, 4'h7); send_frame();
    sweep("R3 row7 pattern");
    // R9 read port follows rd_row_i without a clock
    rd_row_i = 4'h7; #1; check("R9 comb read", rd_data_o, m_mem[7]);

    // R4 overlong frame with junk in front
    fq.delete();
    for (int i = 0; i < 9; i++) fq.push_back(1'b1);
    mk_row(100'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0, 4'h3); send_frame();
    sweep("R4 overlong");

    // R5 short contrast command
    fq.delete(); mk_ctr(4'h6); send_frame();
    check("R5 short cmd", 100'(contrast_o), 100'(4'h6));
    // R5 contrast on a full-length frame, pixel bits ignored
    fq.delete();
    for (int i = 0; i < 100; i++) fq.push_back(1'b1);
    mk_ctr(4'h9); send_frame();
    check("R5 long cmd", 100'(contrast_o), 100'(4'h9));
    sweep("R5 rows untouched");

    // R6 four-bit flagged frame and empty frame ignored
    fq.delete(); fq = {1'b0, 1'b0, 1'b1, 1'b1}; send_frame();
    check("R6 short flagged", 100'(contrast_o), 100'(4'h9));
    check("R6 no err", 100'(short_err_o), 100'(0));
    fq.delete(); send_frame(); sweep("R6 empty frame");

    // R7 truncated row frame
    fq.delete(); mk_row(100'hFFFF, 4'h2);
    for (int i = 0; i < 10; i++) void'(fq.pop_front());
    send_frame();
    check("R7 err set", 100'(short_err_o), 100'(1));
    sweep("R7 no write");
    fq.delete(); mk_ctr(4'h4); send_frame();
    check("R7 err cleared", 100'(short_err_o), 100'(0));

    // R1 clocks with select high are not captured
    chk_en = 1'b0;
    mk_row(100'h3, 4'h5);
    foreach (fq[i]) begin
      sck_i = 1'b0; sdi_i = fq[i]; repeat (5) @(posedge clk);
      sck_i = 1'b1; repeat (5) @(posedge clk);
    end
    fq.delete(); send_frame(); sweep("R1 deselected clocks");

    // R8 reset mid-run
    chk_en = 1'b0;
    rst_ni = 1'b0; model_reset(); #20;
    sweep("R8 reset again");
    check("R8 contrast again", 100'(contrast_o), 100'(4'hF));
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule